// File: doc/BRIEF.md
# Handshaked SPI Transaction Master

This block is the master side of a small message protocol carried over a four-wire SPI link, with three active-low sideband lines added. The slave pulls a host-request line low when it has something to send. The master pulls a slave-request line low to announce each transfer. The slave answers on a slave-ready line: it pulls the line low to grant the transfer and releases it once the master has released its request. The master runs the SPI shifter itself. Clock polarity 0 and clock phase 1 are used, and the clock is divided down from the system clock.

A transaction holds one or two SPI transfers. The first transfer always moves a fixed four bytes in both directions. Byte 0 of each side's message gives that side's total message length, counted in bytes and including byte 0. When the longer of the two lengths is more than four, a second transfer moves the remaining bytes. The downlink message is written into a register array through a write port. The uplink message lands in a second array, which is read through a combinational read port. A transaction can be started by the local side, which sends its downlink buffer, or by the slave's request alone, which sends zero bytes. In both cases the slave's bytes are captured, so every transfer is full duplex.

Top module: `hsSpiMaster`

## Requirements
- R1: Each SPI transfer is preceded by its own handshake. The master drives sreqN low and waits for the synchronised srdyN to go low. It then drives sreqN high and waits for srdyN to go high, and only then lowers ssN. sreqN is high whenever ssN is low.
- R2: The SPI mode is CPOL=0, CPHA=1. sck idles low. mosi changes with each rising sck edge, and miso is sampled at each falling sck edge. Bytes are sent most significant bit first.
- R3: ssN is low only while bits are being shifted. When busy is low, ssN and sreqN are both high.
- R4: A transaction starts from idle when txStart has pulsed or when hreqN is low. When txStart started it, the master sends its downlink buffer. When the start came from hreqN alone, the master sends zero bytes.
- R5: The first transfer is 4 bytes. Byte 0 of the sent message and byte 0 of the received message each give a length, limited to 35. When the larger of the two lengths is more than 4, a second transfer of (larger length - 4) bytes follows. Otherwise the transaction has exactly one transfer.
- R6: Received byte k of the transaction, counted from 0 across both transfers, is stored at uplink address k and can be read on rdData by driving rdAddr=k. Downlink byte k is taken from the address k written through wrEn/wrAddr/wrData.
- R7: When the last transfer ends, txnDone pulses for one cycle. upValid pulses in the same cycle when the received byte 0 is nonzero, and stays low when it is zero.
- R8: If srdyN does not reach the level being waited for within toLimit cycles, the master drives sreqN high and returns to idle without shifting, and txnErr goes high. txnErr stays high until the next transaction starts, and txnDone never pulses while it is high.
- R9: After reset, sreqN=1, ssN=1, sck=0, busy=0, txnErr=0 and txnDone=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txStart | input | 1 | Pulse that requests a downlink transaction |
| wrEn | input | 1 | Write strobe for the downlink buffer |
| wrAddr | input | ADDR_W | Downlink buffer write address |
| wrData | input | 8 | Downlink buffer write data |
| rdAddr | input | ADDR_W | Uplink buffer read address |
| rdData | output | 8 | Uplink buffer byte at rdAddr |
| toLimit | input | TO_W | Handshake wait limit, in clock cycles |
| hreqN | input | 1 | Host request from the slave, active low |
| sreqN | output | 1 | Slave request from the master, active low |
| srdyN | input | 1 | Slave ready, active low |
| ssN | output | 1 | SPI slave select, active low |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data from master to slave |
| miso | input | 1 | SPI data from slave to master |
| busy | output | 1 | A transaction is in progress |
| txnDone | output | 1 | One-cycle pulse at the end of a transaction |
| upValid | output | 1 | One-cycle pulse: the transaction carried an uplink message |
| txnErr | output | 1 | The last transaction timed out during a handshake |

## Verification
A behavioural slave on the bench answers every handshake after a random delay. It shifts its own message out and records the bits it receives. The bench drives length pairs chosen to separate the cases. With lengths of exactly 4, no second transfer may occur. A length of 5 gives a one-byte second transfer. A longer uplink than downlink shows that the larger length sets the size. A length over 35 shows the limit at work, and an uplink length of zero shows upValid stays low. The three start sources are mixed across random transactions, so a downlink buffer sent on a start by host request alone shows up as a data mismatch. A silent slave checks the timeout path, and the transaction after it checks recovery.

// File: rtl/hsSpiPkg.sv
package hsSpiPkg;
  localparam int LEN_W = 6;

  typedef struct packed {
    logic             start;
    logic             second;
    logic [LEN_W-1:0] len;
    logic             useDn;
  } xferCmd_t;
endpackage

// File: rtl/hsSpiCtrl.sv
module hsSpiCtrl
  import hsSpiPkg::*;
#(
  parameter int FIRST_BYTES = 4,
  parameter int MAX_XFER    = 31,
  parameter int TO_W        = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txStart,
  input  logic            hreqN,
  input  logic            srdyN,
  input  logic [TO_W-1:0] toLimit,
  input  logic            xferDone,
  input  logic [7:0]      dnLen0,
  input  logic [7:0]      upLen0,
  output xferCmd_t        cmd,
  output logic            sreqN,
  output logic            busy,
  output logic            txnDone,
  output logic            upValid,
  output logic            txnErr
);
  localparam int TOTAL = FIRST_BYTES + MAX_XFER;
  localparam logic [7:0] TOTAL_B = 8'(TOTAL);
  localparam logic [7:0] FIRST_B = 8'(FIRST_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_REL, S_SHIFT} state_t;

  state_t            state;
  logic [1:0]        hreqSync;
  logic [1:0]        srdySync;
  logic              dnPend;
  logic              useDn;
  logic              second;
  logic [LEN_W-1:0]  secLenReg;
  logic [TO_W-1:0]   waitCnt;
  logic              startGo;
  logic [7:0]        dnEff;
  logic [7:0]        upEff;
  logic [7:0]        maxEff;
  logic [7:0]        secLen;
  logic              srdyLow;
  logic              waitOver;

  function automatic logic [7:0] clampLen(input logic [7:0] v);
    return (v > TOTAL_B) ? TOTAL_B : v;
  endfunction

  // Two-flop synchronisers for the asynchronous sideband inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hreqSync <= 2'b11;
      srdySync <= 2'b11;
    end else begin
      hreqSync <= {hreqSync[0], hreqN};
      srdySync <= {srdySync[0], srdyN};
    end
  end

  always_comb begin
    srdyLow  = ~srdySync[1];
    startGo  = (state == S_IDLE) && (dnPend || !hreqSync[1]);
    waitOver = (waitCnt == toLimit);
    dnEff    = useDn ? clampLen(dnLen0) : 8'd0;
    upEff    = clampLen(upLen0);
    maxEff   = (dnEff > upEff) ? dnEff : upEff;
    secLen   = (maxEff > FIRST_B) ? (maxEff - FIRST_B) : 8'd0;
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dnPend <= 1'b0;
    end else begin
      dnPend <= txStart | (dnPend & ~startGo);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cmd       <= '0;
      sreqN     <= 1'b1;
      useDn     <= 1'b0;
      second    <= 1'b0;
      secLenReg <= '0;
      waitCnt   <= '0;
      txnDone   <= 1'b0;
      upValid   <= 1'b0;
      txnErr    <= 1'b0;
    end else begin
      cmd.start <= 1'b0;
      txnDone   <= 1'b0;
      upValid   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (startGo) begin
            state   <= S_REQ;
            sreqN   <= 1'b0;
            useDn   <= dnPend;
            second  <= 1'b0;
            waitCnt <= '0;
            txnErr  <= 1'b0;
          end
        end
        S_REQ: begin
          if (srdyLow) begin
            sreqN   <= 1'b1;
            waitCnt <= '0;
            state   <= S_REL;
          end else if (waitOver) begin
            sreqN  <= 1'b1;
            txnErr <= 1'b1;
            state  <= S_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_REL: begin
          if (!srdyLow) begin
            state      <= S_SHIFT;
            cmd.start  <= 1'b1;
            cmd.second <= second;
            cmd.len    <= second ? secLenReg : LEN_W'(FIRST_BYTES);
            cmd.useDn  <= useDn;
          end else if (waitOver) begin
            txnErr <= 1'b1;
            state  <= S_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (xferDone) begin
            if (!second && (secLen != 8'd0)) begin
              second    <= 1'b1;
              secLenReg <= secLen[LEN_W-1:0];
              sreqN     <= 1'b0;
              waitCnt   <= '0;
              state     <= S_REQ;
            end else begin
              txnDone <= 1'b1;
              upValid <= (upLen0 != 8'd0);
              state   <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsSpiPath.sv
module hsSpiPath
  import hsSpiPkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int DEPTH       = 35,
  parameter int ADDR_W      = 6,
  parameter int FIRST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferCmd_t          cmd,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ssN,
  output logic              xferDone,
  output logic [7:0]        dnLen0,
  output logic [7:0]        upLen0
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_BYTES);

  logic [7:0]        dnBuf [DEPTH];
  logic [7:0]        upBuf [DEPTH];
  logic              active;
  logic              phHigh;
  logic [DIV_W-1:0]  divCnt;
  logic [2:0]        bitCnt;
  logic [LEN_W-1:0]  byteCnt;
  logic [LEN_W-1:0]  lenReg;
  logic [ADDR_W-1:0] baseReg;
  logic              useDnReg;
  logic [7:0]        shReg;
  logic              tick;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] cmdBase;
  logic [7:0]        rxByte;

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr < DEPTH_A)) dnBuf[wrAddr] <= wrData;
  end

  always_comb begin
    tick     = (divCnt == DIV_W'(CLK_DIV - 1));
    curAddr  = baseReg + ADDR_W'(byteCnt);
    nextAddr = curAddr + 1'b1;
    cmdBase  = cmd.second ? FIRST_A : '0;
    rxByte   = {shReg[6:0], miso};
    rdData   = (rdAddr < DEPTH_A) ? upBuf[rdAddr] : 8'd0;
    dnLen0   = dnBuf[0];
    upLen0   = upBuf[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) upBuf[i] <= 8'd0;
      active   <= 1'b0;
      phHigh   <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      lenReg   <= '0;
      baseReg  <= '0;
      useDnReg <= 1'b0;
      shReg    <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      ssN      <= 1'b1;
      xferDone <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      if (cmd.start) begin
        active   <= 1'b1;
        ssN      <= 1'b0;
        sck      <= 1'b0;
        phHigh   <= 1'b0;
        divCnt   <= '0;
        bitCnt   <= '0;
        byteCnt  <= '0;
        lenReg   <= cmd.len;
        baseReg  <= cmdBase;
        useDnReg <= cmd.useDn;
        shReg    <= (cmd.useDn && (cmdBase < DEPTH_A)) ? dnBuf[cmdBase] : 8'd0;
      end else if (active) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (!phHigh) begin
            if (byteCnt == lenReg) begin
              active   <= 1'b0;
              ssN      <= 1'b1;
              mosi     <= 1'b0;
              xferDone <= 1'b1;
            end else begin
              sck    <= 1'b1;
              mosi   <= shReg[7];
              phHigh <= 1'b1;
            end
          end else begin
            sck    <= 1'b0;
            phHigh <= 1'b0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              if (curAddr < DEPTH_A) upBuf[curAddr] <= rxByte;
              byteCnt <= byteCnt + 1'b1;
              shReg   <= (useDnReg && (nextAddr < DEPTH_A)) ? dnBuf[nextAddr] : 8'd0;
            end else begin
              shReg <= rxByte;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hsSpiMaster.sv
module hsSpiMaster
  import hsSpiPkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int FIRST_BYTES = 4,
  parameter int MAX_XFER    = 31,
  parameter int TO_W        = 16,
  localparam int DEPTH      = FIRST_BYTES + MAX_XFER,
  localparam int ADDR_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic [TO_W-1:0]   toLimit,
  input  logic              hreqN,
  output logic              sreqN,
  input  logic              srdyN,
  output logic              ssN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              txnDone,
  output logic              upValid,
  output logic              txnErr
);
  xferCmd_t   cmd;
  logic       xferDone;
  logic [7:0] dnLen0;
  logic [7:0] upLen0;

  hsSpiCtrl #(
    .FIRST_BYTES(FIRST_BYTES), .MAX_XFER(MAX_XFER), .TO_W(TO_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .hreqN(hreqN), .srdyN(srdyN),
    .toLimit(toLimit), .xferDone(xferDone), .dnLen0(dnLen0), .upLen0(upLen0),
    .cmd(cmd), .sreqN(sreqN), .busy(busy), .txnDone(txnDone),
    .upValid(upValid), .txnErr(txnErr)
  );

  hsSpiPath #(
    .CLK_DIV(CLK_DIV), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .FIRST_BYTES(FIRST_BYTES)
  ) i_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .miso(miso),
    .sck(sck), .mosi(mosi), .ssN(ssN), .xferDone(xferDone),
    .dnLen0(dnLen0), .upLen0(upLen0)
  );
endmodule

// File: rtl/hsSpiChecker.sv
module hsSpiChecker (
  input logic clk,
  input logic rstN,
  input logic ssN,
  input logic sck,
  input logic sreqN,
  input logic busy,
  input logic txnDone,
  input logic upValid,
  input logic txnErr
);
  // R1: the request line is released for the whole time data shifts
  a_r1_sreq_high_in_shift: assert property (@(posedge clk) disable iff (!rstN)
    !ssN |-> sreqN);

  // R2: serial clock idles low outside a selected transfer
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sck);

  // R2: a rising clock edge only appears with the slave selected
  a_r2_sck_rise_selected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> !ssN);

  // R3: all outgoing lines are quiet when no transaction is running
  a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssN && sreqN));

  // R7: the uplink strobe only comes with the end-of-transaction pulse
  a_r7_upvalid_with_done: assert property (@(posedge clk) disable iff (!rstN)
    upValid |-> txnDone);

  // R8: a completed transaction never carries the error flag
  a_r8_done_without_err: assert property (@(posedge clk) disable iff (!rstN)
    txnDone |-> !txnErr);
endmodule

bind hsSpiMaster hsSpiChecker i_chk (
  .clk(clk), .rstN(rstN), .ssN(ssN), .sck(sck), .sreqN(sreqN), .busy(busy),
  .txnDone(txnDone), .upValid(upValid), .txnErr(txnErr)
);

// File: tb/test_hsSpiMaster.sv
module test_hsSpiMaster;
  localparam int DEPTH = 35;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txStart = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [5:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [15:0] toLimit = 16'd200;
  logic       hreqN = 1'b1;
  logic       sreqN;
  logic       srdyN = 1'b1;
  logic       ssN;
  logic       sck;
  logic       mosi;
  logic       miso = 1'b0;
  logic       busy;
  logic       txnDone;
  logic       upValid;
  logic       txnErr;

  int nChecks = 0;
  int nFail = 0;
  int doneCnt = 0;
  int upvCnt = 0;
  int idleViol = 0;
  int ssFallCnt = 0;
  int sBits = 0;
  int sReqCnt = 0;
  int hsDly = 2;
  bit mute = 1'b0;
  logic [7:0] sUp [DEPTH];
  logic [7:0] sRx [DEPTH];
  logic [7:0] dnMem [DEPTH];

  always #2 clk = ~clk;

  hsSpiMaster i_hsSpiMaster (
    .clk(clk), .rstN(rstN), .txStart(txStart), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .toLimit(toLimit),
    .hreqN(hreqN), .sreqN(sreqN), .srdyN(srdyN), .ssN(ssN), .sck(sck),
    .mosi(mosi), .miso(miso), .busy(busy), .txnDone(txnDone),
    .upValid(upValid), .txnErr(txnErr)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (txnDone) doneCnt <= doneCnt + 1;
      if (upValid) upvCnt <= upvCnt + 1;
      if (!ssN && !busy) idleViol <= idleViol + 1;
    end
  end

  always @(negedge ssN) if (rstN) ssFallCnt++;

  // Behavioural slave: handshake side
  always begin
    @(negedge sreqN);
    hreqN = 1'b1;
    sReqCnt++;
    if (!mute) begin
      repeat (hsDly) @(negedge clk);
      srdyN = 1'b0;
      @(posedge sreqN);
      repeat (hsDly) @(negedge clk);
      srdyN = 1'b1;
    end
  end

  // Behavioural slave: shift side (present on rising, sample on falling)
  always @(posedge sck) begin
    if (!ssN && (sBits / 8 < DEPTH)) miso = sUp[sBits / 8][7 - (sBits % 8)];
  end
  always @(negedge sck) begin
    if (!ssN) begin
      if (sBits / 8 < DEPTH) sRx[sBits / 8][7 - (sBits % 8)] = mosi;
      sBits++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampLen(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  // mode 0: local start, 1: slave request only, 2: both
  task automatic runTxn(input int mode, input int dnL, input int upL, input int dly);
    int d0, u0, dnE, upE, mx, total, xfers, bad, badIdx, badAct, badExp, cyc;
    for (int i = 0; i < DEPTH; i++) begin
      dnMem[i] = (i == 0) ? 8'(dnL) : 8'($urandom);
      sUp[i]   = (i == 0) ? 8'(upL) : 8'($urandom);
      sRx[i]   = 8'h00;
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 6'(i); wrData = dnMem[i];
    end
    @(negedge clk);
    wrEn = 1'b0;
    sBits = 0; sReqCnt = 0; hsDly = dly;
    d0 = doneCnt; u0 = upvCnt;
    if (mode != 1) txStart = 1'b1;
    if (mode != 0) hreqN = 1'b0;
    @(negedge clk);
    txStart = 1'b0;
    cyc = 0;
    while (doneCnt == d0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    dnE = (mode != 1) ? clampLen(dnL) : 0;
    upE = clampLen(upL);
    mx = (dnE > upE) ? dnE : upE;
    total = (mx > 4) ? mx : 4;
    xfers = (mx > 4) ? 2 : 1;
    check(doneCnt - d0 == 1, "R7 done pulse count", doneCnt - d0, 1);
    check(upvCnt - u0 == ((upE != 0) ? 1 : 0), "R7 upValid count", upvCnt - u0,
          (upE != 0) ? 1 : 0);
    check(sBits == 8 * total, "R5 bits shifted", sBits, 8 * total);
    check(sReqCnt == xfers, "R1 handshakes per transaction", sReqCnt, xfers);
    bad = 0; badIdx = 0; badAct = 0; badExp = 0;
    for (int i = 0; i < total; i++) begin
      int e;
      e = (mode != 1) ? int'(dnMem[i]) : 0;
      if (int'(sRx[i]) != e) begin
        if (bad == 0) begin badIdx = i; badAct = int'(sRx[i]); badExp = e; end
        bad++;
      end
    end
    check(bad == 0, $sformatf("R4 downlink byte %0d", badIdx), badAct, badExp);
    bad = 0;
    for (int i = 0; i < total; i++) begin
      rdAddr = 6'(i);
      #1;
      if (rdData != sUp[i]) begin
        if (bad == 0) begin badIdx = i; badAct = int'(rdData); badExp = int'(sUp[i]); end
        bad++;
      end
    end
    check(bad == 0, $sformatf("R6 uplink byte %0d", badIdx), badAct, badExp);
    check(idleViol == 0, "R3 select low while idle", idleViol, 0);
    check(txnErr == 1'b0, "R8 no error on good transaction", int'(txnErr), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int f0, d0, cyc;
    void'($urandom(32'h1234abcd));
    repeat (4) @(negedge clk);
    check(sreqN == 1'b1, "R9 reset sreqN", int'(sreqN), 1);
    check(ssN == 1'b1, "R9 reset ssN", int'(ssN), 1);
    check(sck == 1'b0, "R9 reset sck", int'(sck), 0);
    check(busy == 1'b0 && txnErr == 1'b0 && txnDone == 1'b0,
          "R9 reset status", int'({busy, txnErr, txnDone}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 idle after reset", int'(busy), 0);

    // Directed corner cases
    runTxn(0, 4, 0, 1);     // R5 exactly first size, single transfer
    runTxn(0, 5, 0, 3);     // R5 one-byte second transfer
    runTxn(1, 0, 9, 2);     // R4 slave-request start, uplink sets size
    runTxn(2, 35, 35, 4);   // R5 largest lengths
    runTxn(0, 40, 200, 1);  // R5 lengths above the limit
    runTxn(1, 0, 0, 5);     // R7 empty uplink, no upValid
    runTxn(0, 3, 6, 2);     // R5 uplink longer than downlink

    // Random transactions
    for (int t = 0; t < 20; t++) begin
      runTxn(int'($urandom_range(0, 2)), int'($urandom_range(0, 40)),
             int'($urandom_range(0, 40)), int'($urandom_range(1, 10)));
    end

    // R8 timeout: the slave never answers
    mute = 1'b1;
    toLimit = 16'd50;
    f0 = ssFallCnt; d0 = doneCnt;
    @(negedge clk);
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    cyc = 0;
    while (!txnErr && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (3) @(negedge clk);
    check(txnErr == 1'b1, "R8 error flag on timeout", int'(txnErr), 1);
    check(busy == 1'b0 && sreqN == 1'b1, "R8 back to idle", int'({busy, sreqN}), 1);
    check(ssFallCnt == f0, "R8 no shifting on timeout", ssFallCnt - f0, 0);
    check(doneCnt == d0, "R8 no done on timeout", doneCnt - d0, 0);
    mute = 1'b0;
    toLimit = 16'd200;
    repeat (5) @(negedge clk);
    runTxn(0, 12, 7, 2);    // R8 recovery clears the flag

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule